// File: doc/BRIEF.md
# Serial EEPROM Slave with Three-Wire Command Port

This block models the digital side of a 8192-bit serial EEPROM that is driven over a three-wire synchronous command port: a select line, a serial clock and a serial data input, plus a serial data output with a separate output enable. The serial clock and select are sampled by a faster system clock, and every action happens on the system-clock edge that sees a serial-clock or select transition. The storage is a register array. A word-size input chooses 16-bit words (input high) or 8-bit bytes (input low). The choice changes the address length and the data length of every command.

A host selects the block, clocks in a start bit, an opcode and an address, and then either reads data or supplies write data. Reads can continue across word boundaries for as long as the select line stays high. Writes and erases run for a fixed number of system clocks after the select line drops. During that time the output reports busy or ready whenever the block is selected. Writes are refused until software enables them.

Top module: `mw_eeprom`

## Requirements
- R1: With select high, serial input is sampled on each serial-clock rise. While idle, 0 bits are skipped and a 1 is the start bit. Next come a 2-bit opcode (10 read, 01 write, 11 erase, 00 control) and the address, MSB first. The address is 10 bits when the word-size input is high (16-bit words) and 11 bits when it is low (bytes).
- R2: The first (most significant) address bit is shifted in but has no effect on which location is used.
- R3: On the serial-clock rise that takes the last read-address bit, the output is enabled and drives 0. Each later rise presents the next bit of the addressed word, MSB first.
- R4: After the last bit of a word, the next rise gives the MSB of the following word with no extra 0 bit. The address wraps from 511 (16-bit mode) or 1023 (byte mode) to 0.
- R5: A write takes 16 data bits (16-bit mode) or 8 data bits (byte mode) after the address. The fall of select starts the store. After the busy period the location holds exactly the new data, whatever it held before. A 16-bit word n occupies bytes 2n (high half) and 2n+1 (low half).
- R6: An erase sets every bit of the addressed location to 1 once the busy period has ended.
- R7: After reset, writes and erases leave the memory unchanged and start no busy period. A control command whose two leading address bits are 11 enables them, and one whose two leading address bits are 00 disables them again.
- R8: An enabled write or erase holds the block busy for BUSY_CYCLES system clocks. Whenever select is high from then until the status is released, the output is enabled and shows 0 while busy and 1 once ready.
- R9: A 1 sampled on a serial-clock rise while status is shown disables the output on the next serial-clock fall. When the block is ready, that same 1 also counts as the start bit of a new command.
- R10: Commands clocked in while busy are ignored and drive nothing on the output.
- R11: Reset leaves the output disabled. When select goes low, the output is disabled on the next system clock and a partly received command is discarded without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Select, active high |
| sk_i | input | 1 | Serial clock, sampled by clk_i |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Word size: 1 = 16-bit, 0 = 8-bit |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
Reads are tried in both word sizes, with and without leading zeros before the start bit, and as multi-word runs that cross the top address. This separates a correct wrap from a stuck or doubled dummy bit. Writes overwrite a value that shares bits with the new data, so a stored AND or OR of old and new data would show. A byte written in byte mode is read back through a 16-bit word to pin down how the halves are ordered. Status is polled in two ways: released while ready, and released while busy and followed by a read that must stay silent. The protection latch is tested with writes and erases both before it is enabled and after it is disabled.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_DATA,
    S_READ,
    S_HOLD
  } mw_st_e;

  typedef enum logic [1:0] {
    OP_CTL = 2'b00,
    OP_WR  = 2'b01,
    OP_RD  = 2'b10,
    OP_ER  = 2'b11
  } mw_op_e;

  localparam int unsigned DW_WIDE   = 16;
  localparam int unsigned DW_NARROW = 8;
endpackage

// File: rtl/mw_rx.sv
module mw_rx #(
  parameter int unsigned FR_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            shift_i,
  input  logic            di_i,
  output logic [FR_W-1:0] frame_o
);
  logic [FR_W-2:0] sr_q;

  assign frame_o = {sr_q, di_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clr_i)   sr_q <= '0;
    else if (shift_i) sr_q <= frame_o[FR_W-2:0];
  end

  // R11
  clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sr_q == '0));
endmodule

// File: rtl/mw_busy.sv
module mw_busy #(
  parameter int unsigned CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));

  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  // R8
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
endmodule

// File: rtl/mw_mem.sv
module mw_mem #(
  parameter int unsigned BYTES = 1024
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     wide_i,
  input  logic [$clog2(BYTES)-1:0] addr_i,
  input  logic [15:0]              wdata_i,
  output logic [15:0]              rdata_o
);
  localparam int unsigned BA_W = $clog2(BYTES);

  logic [7:0]      mem_q [BYTES];
  logic [BA_W-1:0] hi_idx, lo_idx;

  assign hi_idx = {addr_i[BA_W-2:0], 1'b0};
  assign lo_idx = {addr_i[BA_W-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      if (wide_i) begin
        mem_q[hi_idx] <= wdata_i[15:8];
        mem_q[lo_idx] <= wdata_i[7:0];
      end else begin
        mem_q[addr_i] <= wdata_i[7:0];
      end
    end
  end

  assign rdata_o = wide_i ? {mem_q[hi_idx], mem_q[lo_idx]} : {8'h00, mem_q[addr_i]};
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int unsigned MEM_BITS    = 8192,
  parameter int unsigned BUSY_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int unsigned BYTES = MEM_BITS / 8;
  localparam int unsigned BA_W  = $clog2(BYTES);
  localparam int unsigned WA_W  = BA_W - 1;
  localparam int unsigned AW16  = WA_W + 1;
  localparam int unsigned AW8   = BA_W + 1;
  localparam int unsigned HL16  = 2 + AW16;
  localparam int unsigned HL8   = 2 + AW8;
  localparam int unsigned FR_W  = (HL8 > DW_WIDE) ? HL8 : DW_WIDE;
  localparam int unsigned CNT_W = $clog2(FR_W + 1);
  localparam int unsigned BI_W  = $clog2(DW_WIDE + 1);

  mw_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BI_W-1:0]  bidx_q;
  logic [BA_W-1:0]  a_q;
  logic [15:0]      wdat_q;
  logic             wide_q, er_q, arm_q, wel_q;
  logic             pend_q, hide_q, rel_q;
  logic             sk_q, cs_q, do_q, oe_q;

  logic             sk_rise, sk_fall, cs_fall;
  logic             busy, done, busy_start, show;
  logic [FR_W-1:0]  frame;
  logic [15:0]      rd_word;
  logic [CNT_W-1:0] hlen;
  logic [BI_W-1:0]  dlen;
  mw_op_e           op_dec;
  logic [BA_W-1:0]  addr_dec, a_nx;
  logic [1:0]       ctl_dec;
  logic [15:0]      wdat_dec;

  assign sk_rise = cs_i & sk_i & ~sk_q;
  assign sk_fall = cs_i & ~sk_i & sk_q;
  assign cs_fall = ~cs_i & cs_q;

  assign busy_start = cs_fall & arm_q & wel_q & ~busy;
  assign show       = cs_i & (busy | pend_q) & ~hide_q;

  assign hlen     = wide_q ? CNT_W'(HL16) : CNT_W'(HL8);
  assign dlen     = wide_q ? BI_W'(DW_WIDE) : BI_W'(DW_NARROW);
  assign op_dec   = mw_op_e'(wide_q ? frame[HL16-1 -: 2] : frame[HL8-1 -: 2]);
  // leading address bit dropped in both modes
  assign addr_dec = wide_q ? {1'b0, frame[AW16-2:0]} : frame[AW8-2:0];
  assign ctl_dec  = wide_q ? frame[AW16-1 -: 2] : frame[AW8-1 -: 2];
  assign wdat_dec = wide_q ? frame[15:0] : {8'h00, frame[7:0]};
  assign a_nx     = wide_q ? {1'b0, a_q[WA_W-1:0] + WA_W'(1)} : a_q + BA_W'(1);

  mw_rx #(.FR_W(FR_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (~cs_i | (st_q == S_IDLE)),
    .shift_i (sk_rise & ((st_q == S_HDR) | (st_q == S_DATA))),
    .di_i    (di_i),
    .frame_o (frame)
  );

  mw_busy #(.CYC(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (busy_start),
    .busy_o  (busy),
    .done_o  (done)
  );

  mw_mem #(.BYTES(BYTES)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done),
    .wide_i  (wide_q),
    .addr_i  (a_q),
    .wdata_i (er_q ? 16'hFFFF : wdat_q),
    .rdata_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk_i;
      cs_q <= cs_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      a_q    <= '0;
      wdat_q <= '0;
      wide_q <= 1'b1;
      er_q   <= 1'b0;
      arm_q  <= 1'b0;
      wel_q  <= 1'b0;
      pend_q <= 1'b0;
      hide_q <= 1'b0;
      rel_q  <= 1'b0;
      do_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else if (!cs_i) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
      do_q   <= 1'b0;
      hide_q <= 1'b0;
      rel_q  <= 1'b0;
      arm_q  <= 1'b0;
      if (busy_start)           pend_q <= 1'b1;
      else if (cs_fall && !busy) pend_q <= 1'b0;
    end else if (show) begin
      oe_q <= 1'b1;
      do_q <= ~busy;
      if (sk_rise && di_i) begin
        rel_q <= 1'b1;
        if (!busy) begin
          // ready: the releasing 1 doubles as a start bit
          st_q   <= S_HDR;
          cnt_q  <= '0;
          wide_q <= org_i;
        end
      end
      if (sk_fall && rel_q) begin
        hide_q <= 1'b1;
        rel_q  <= 1'b0;
        oe_q   <= 1'b0;
        if (!busy) pend_q <= 1'b0;
      end
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (sk_rise && di_i && !busy) begin
            st_q   <= S_HDR;
            cnt_q  <= '0;
            wide_q <= org_i;
          end
        end
        S_HDR: begin
          if (sk_rise) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == hlen - CNT_W'(1)) begin
              unique case (op_dec)
                OP_RD: begin
                  st_q   <= S_READ;
                  a_q    <= addr_dec;
                  oe_q   <= 1'b1;
                  do_q   <= 1'b0;
                  bidx_q <= dlen;
                end
                OP_WR: begin
                  st_q  <= S_DATA;
                  a_q   <= addr_dec;
                  cnt_q <= '0;
                end
                OP_ER: begin
                  st_q  <= S_HOLD;
                  a_q   <= addr_dec;
                  er_q  <= 1'b1;
                  arm_q <= 1'b1;
                end
                OP_CTL: begin
                  st_q <= S_HOLD;
                  if (ctl_dec == 2'b11)      wel_q <= 1'b1;
                  else if (ctl_dec == 2'b00) wel_q <= 1'b0;
                end
                default: st_q <= S_HOLD;
              endcase
            end
          end
        end
        S_DATA: begin
          if (sk_rise) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(dlen) - CNT_W'(1)) begin
              wdat_q <= wdat_dec;
              er_q   <= 1'b0;
              arm_q  <= 1'b1;
              st_q   <= S_HOLD;
            end
          end
        end
        S_READ: begin
          if (sk_rise) begin
            do_q <= rd_word[4'(bidx_q - BI_W'(1))];
            if (bidx_q == BI_W'(1)) begin
              bidx_q <= dlen;
              a_q    <= a_nx;
            end else begin
              bidx_q <= bidx_q - BI_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign do_o    = do_q;
  assign do_oe_o = oe_q;

  // R11
  cs_low_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !do_oe_o);
  // R10
  busy_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (st_q == S_IDLE));
  // R7
  store_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> wel_q);
  // R3
  read_dummy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(do_oe_o) && (st_q == S_READ)) |-> !do_o);
  // R8
  busy_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(show && busy && !(sk_fall && rel_q)) |-> (do_oe_o && !do_o));
endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  localparam int BUSY = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_w, oe_w;

  always #5 clk = ~clk;

  mw_eeprom #(.MEM_BITS(8192), .BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .org_i(org), .do_o(do_w), .do_oe_o(oe_w)
  );

  int    checks = 0, fails = 0;
  logic  exp_oe = 1'b0, exp_do = 1'b0;
  bit    do_dc = 1'b0, chk_on = 1'b0, done_flag = 1'b0;
  string req = "R11";
  logic [7:0] ref_mem [1024];
  bit    ref_wel = 1'b0;

  // per-clock comparison against the bench model
  always @(negedge clk) begin
    if (chk_on) begin
      checks++;
      if (oe_w !== exp_oe || (exp_oe && !do_dc && do_w !== exp_do)) begin
        fails++;
        $display("FAIL %s t=%0t oe=%b do=%b expected oe=%b do=%b",
                 req, $time, oe_w, do_w, exp_oe, exp_do);
      end
    end
  end

  task automatic check(string r, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", r, $time, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_cyc(logic d, logic r_oe, logic r_do, logic f_oe, logic f_do);
    @(negedge clk) di = d;
    @(negedge clk) sk = 1'b1;
    @(posedge clk) #1 begin exp_oe = r_oe; exp_do = r_do; end
    @(negedge clk);
    @(negedge clk) sk = 1'b0;
    @(posedge clk) #1 begin exp_oe = f_oe; exp_do = f_do; end
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) sk_cyc(v[i], exp_oe, exp_do, exp_oe, exp_do);
  endtask

  task automatic cs_up();
    @(negedge clk) cs = 1'b1;
    @(posedge clk) #1;
  endtask

  task automatic cs_dn();
    @(negedge clk) begin cs = 1'b0; di = 1'b0; end
    @(posedge clk) #1 exp_oe = 1'b0;
    tick(2);
  endtask

  function automatic logic [15:0] ref_rd(bit wide, int a);
    if (wide) return {ref_mem[2 * (a % 512)], ref_mem[2 * (a % 512) + 1]};
    return {8'h00, ref_mem[a % 1024]};
  endfunction

  task automatic do_instr(bit wide, logic [1:0] op, int addr, logic [15:0] data, bit has_data);
    org = wide;
    sk_cyc(1'b1, exp_oe, exp_do, exp_oe, exp_do);
    send_bits({30'd0, op}, 2);
    send_bits(addr, wide ? 10 : 11);
    if (has_data) send_bits({16'd0, data}, wide ? 16 : 8);
  endtask

  task automatic do_read(bit wide, int addr, int nwords, int lead0, string r);
    int a, aw, dw;
    logic [15:0] w;
    req = r;
    org = wide;
    aw = wide ? 10 : 11;
    dw = wide ? 16 : 8;
    cs_up();
    send_bits(0, lead0);
    sk_cyc(1'b1, 0, 0, 0, 0);
    send_bits(32'h2, 2);
    for (int i = aw - 1; i >= 1; i--) sk_cyc(addr[i], 0, 0, 0, 0);
    sk_cyc(addr[0], 1, 0, 1, 0);                // R3 dummy zero
    a = wide ? addr % 512 : addr % 1024;
    for (int k = 0; k < nwords; k++) begin
      w = ref_rd(wide, a);
      for (int b = dw - 1; b >= 0; b--) sk_cyc(1'b0, 1, w[b], 1, w[b]);
      a = wide ? (a + 1) % 512 : (a + 1) % 1024;  // R4 wrap
    end
    cs_dn();
  endtask

  task automatic status_poll(bit release_busy);
    tick(3);
    cs_up();
    exp_oe = 1'b1; exp_do = 1'b0;
    @(negedge clk);
    check("R8 busy oe", oe_w, 1'b1);
    check("R8 busy level", do_w, 1'b0);
    if (!release_busy) begin
      do_dc = 1'b1;
      tick(BUSY + 10);
      do_dc = 1'b0;
      exp_do = 1'b1;
      tick(2);
      check("R8 ready level", do_w, 1'b1);
      sk_cyc(1'b1, 1, 1, 0, 1);
      check("R9 release when ready", oe_w, 1'b0);
      cs_dn();
    end else begin
      req = "R9";
      sk_cyc(1'b1, 1, 0, 0, 0);
      check("R9 release while busy", oe_w, 1'b0);
      req = "R10";
      do_instr(1'b1, 2'b10, 5, 16'h0, 1'b0);
      send_bits(0, 2);
      check("R10 read ignored while busy", oe_w, 1'b0);
      cs_dn();
      tick(BUSY);
      req = "R8";
      cs_up();
      exp_oe = 1'b1; exp_do = 1'b1;
      @(negedge clk);
      check("R8 ready after busy", do_w, 1'b1);
      sk_cyc(1'b1, 1, 1, 0, 1);
      cs_dn();
    end
  endtask

  task automatic do_write(bit wide, int addr, logic [15:0] data, bit mode, string r);
    int a;
    req = r;
    cs_up();
    do_instr(wide, 2'b01, addr, data, 1'b1);
    cs_dn();
    if (ref_wel) begin
      if (wide) begin
        a = addr % 512;
        ref_mem[2 * a] = data[15:8];
        ref_mem[2 * a + 1] = data[7:0];
      end else begin
        ref_mem[addr % 1024] = data[7:0];
      end
      status_poll(mode);
    end else begin
      tick(3);
      cs_up();
      tick(2);
      check("R7 no busy when protected", oe_w, 1'b0);
      cs_dn();
    end
  endtask

  task automatic do_erase(int addr, string r);
    int a;
    req = r;
    cs_up();
    do_instr(1'b1, 2'b11, addr, 16'h0, 1'b0);
    cs_dn();
    if (ref_wel) begin
      a = addr % 512;
      ref_mem[2 * a] = 8'hFF;
      ref_mem[2 * a + 1] = 8'hFF;
      status_poll(1'b0);
    end else begin
      tick(3);
    end
  endtask

  task automatic do_ctl(bit en);
    req = "R7";
    cs_up();
    do_instr(1'b1, 2'b00, en ? 32'h300 : 32'h000, 16'h0, 1'b0);
    cs_dn();
    ref_wel = en;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
    tick(3);
    check("R11 reset oe", oe_w, 1'b0);
    rst_n = 1'b1;
    tick(2);
    chk_on = 1'b1;

    do_write(1'b1, 5, 16'hA5C3, 1'b0, "R7");
    do_read(1'b1, 5, 1, 0, "R7");
    do_ctl(1'b1);
    do_write(1'b1, 5, 16'h1234, 1'b0, "R5");
    do_read(1'b1, 5, 1, 2, "R1");
    do_write(1'b1, 5 + 512, 16'h00F0, 1'b1, "R2");
    do_read(1'b1, 5, 1, 0, "R5");
    do_write(1'b1, 0, 16'hBEEF, 1'b0, "R5");
    do_write(1'b1, 511, 16'h5A5A, 1'b0, "R5");
    do_read(1'b1, 510, 3, 0, "R4");
    do_write(1'b0, 3, 16'h007E, 1'b0, "R5");
    do_read(1'b0, 2, 2, 1, "R1");
    do_read(1'b1, 1, 1, 0, "R5");
    do_read(1'b0, 1023 + 1024, 2, 0, "R4");
    do_erase(5, "R6");
    do_read(1'b1, 5, 1, 0, "R6");
    do_ctl(1'b0);
    do_write(1'b1, 5, 16'h0000, 1'b0, "R7");
    do_erase(0, "R7");
    do_read(1'b1, 4, 3, 0, "R7");

    // R11 abort mid-command
    req = "R11";
    cs_up();
    sk_cyc(1'b1, 0, 0, 0, 0);
    send_bits(32'h1, 2);
    send_bits(32'h5, 4);
    cs_dn();
    check("R11 oe after abort", oe_w, 1'b0);
    do_read(1'b1, 5, 1, 0, "R11");

    chk_on = 1'b0;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule